// File: doc/BRIEF.md
# Double-Column Hit Collector with Test Isolation

The collector sits at the foot of a pixel matrix that is organised as 32 double-columns. Each double-column offers 22-bit hit words through its own four-phase request/acknowledge port. The collector picks one requesting column at a time and adds that column's 5-bit index to the word. It then offers the 27-bit result on a single four-phase output port.

The collector acknowledges a column only after the downstream side has taken the word and released its acknowledge. Both handshakes return to zero before the next column is chosen. Columns are served in round-robin order, so no column can starve.

A test mode narrows service to one chosen double-column. Every other column keeps its acknowledge low, so its pending request is held rather than dropped. The mode bit and the column select are looked at only between transfers.

Top module: `col_collector`

## Requirements
- R1: While rst_ni is low and in the first cycle after reset, out_req_o is low and every bit of in_ack_o is low.
- R2: The output word carries the column index in bits [26:22] and that column's 22-bit input word in bits [21:0].
- R3: When the block is idle and an eligible request is present at a rising clock edge, out_req_o is high after that edge. It then stays high with out_data_o unchanged until out_ack_i is seen high.
- R4: A column's acknowledge rises only after out_ack_i has been seen high and then low again. It stays high until that column's request falls, and then it falls.
- R5: At most one bit of in_ack_o is high at any time.
- R6: After column c has been served, the next column served is the first one with a pending request in the order c+1, c+2, … wrapping past 31 to 0. After reset the search starts at column 0.
- R7: With test mode on (test_en_i=1), only the column indexed by test_sel_i is served. Other columns get no acknowledge and keep their requests pending. Those requests are served once test mode is turned off.
- R8: test_en_i and test_sel_i act only while the block is idle. A change during a transfer does not alter that transfer. It applies from the next choice onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_req_i | input | 32 | Request, one bit per double-column |
| in_ack_o | output | 32 | Acknowledge, one bit per double-column |
| in_data_i | input | 704 | 22-bit words, column g in bits [22g+21:22g] |
| out_req_o | output | 1 | Output request |
| out_ack_i | input | 1 | Output acknowledge |
| out_data_o | output | 27 | {column index, hit word} |
| test_en_i | input | 1 | 1 = serve only the selected column |
| test_sel_i | input | 5 | Column served in test mode |

## Verification
The assertions assume that every column and the sink follow four-phase rules. A column holds its request and data until it is acknowledged, and lowers its request only while acknowledged. The sink raises out_ack_i only during a request and holds it until the request falls.

The bench plays all 32 columns and the sink from a single sequential flow. It changes requests only when no handshake is open and never withdraws an unserved request, so the stimulus stays inside those rules. Random request patterns, data and mode switches are mixed with directed cases: wrap-around, test isolation, and a mode change during a transfer.

// File: rtl/col_collector_pkg.sv
package col_collector_pkg;
  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_OUT_REQ = 2'd1,
    ST_OUT_REL = 2'd2,
    ST_IN_ACK  = 2'd3
  } cc_state_e;
endpackage

// File: rtl/cc_eligible.sv
module cc_eligible #(
  parameter int N_COLS = 32,
  parameter int COL_W  = $clog2(N_COLS)
) (
  input  logic [N_COLS-1:0] req_i,
  input  logic              test_en_i,
  input  logic [COL_W-1:0]  test_sel_i,
  output logic [N_COLS-1:0] elig_o
);
  for (genvar g = 0; g < N_COLS; g++) begin : g_col
    assign elig_o[g] = req_i[g] & (~test_en_i | (test_sel_i == COL_W'(g)));
  end
endmodule

// File: rtl/cc_rr_pick.sv
module cc_rr_pick #(
  parameter int N_COLS = 32,
  parameter int COL_W  = $clog2(N_COLS)
) (
  input  logic [N_COLS-1:0] req_i,
  input  logic [COL_W-1:0]  last_i,
  output logic              valid_o,
  output logic [COL_W-1:0]  idx_o
);
  // lowest priority goes to the column served last
  always_comb begin
    int p;
    valid_o = 1'b0;
    idx_o   = '0;
    for (int k = 1; k <= N_COLS; k++) begin
      p = (int'(last_i) + k) % N_COLS;
      if (!valid_o && req_i[p]) begin
        valid_o = 1'b1;
        idx_o   = COL_W'(p);
      end
    end
  end
endmodule

// File: rtl/cc_ctrl.sv
module cc_ctrl
  import col_collector_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      any_i,
  input  logic      out_ack_i,
  input  logic      sel_req_i,
  output cc_state_e state_o,
  output logic      grant_o
);
  cc_state_e state_d, state_q;

  always_comb begin
    state_d = state_q;
    grant_o = 1'b0;
    unique case (state_q)
      ST_IDLE: if (any_i) begin
        state_d = ST_OUT_REQ;
        grant_o = 1'b1;
      end
      ST_OUT_REQ: if (out_ack_i)  state_d = ST_OUT_REL;
      ST_OUT_REL: if (!out_ack_i) state_d = ST_IN_ACK;
      ST_IN_ACK:  if (!sel_req_i) state_d = ST_IDLE;
      default:    state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  assign state_o = state_q;
endmodule

// File: rtl/col_collector.sv
module col_collector
  import col_collector_pkg::*;
#(
  parameter int N_COLS = 32,
  parameter int DATA_W = 22,
  parameter int COL_W  = $clog2(N_COLS),
  parameter int OUT_W  = COL_W + DATA_W
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [N_COLS-1:0]        in_req_i,
  output logic [N_COLS-1:0]        in_ack_o,
  input  logic [N_COLS*DATA_W-1:0] in_data_i,
  output logic                     out_req_o,
  input  logic                     out_ack_i,
  output logic [OUT_W-1:0]         out_data_o,
  input  logic                     test_en_i,
  input  logic [COL_W-1:0]         test_sel_i
);
  logic [N_COLS-1:0] elig;
  logic              pick_vld;
  logic [COL_W-1:0]  pick_idx;
  logic              grant;
  cc_state_e         state;

  logic [COL_W-1:0]  col_q;
  logic [DATA_W-1:0] data_q;
  logic [COL_W-1:0]  last_q;
  logic              test_q;
  logic [COL_W-1:0]  sel_q;

  cc_eligible #(.N_COLS(N_COLS), .COL_W(COL_W)) u_elig (
    .req_i      (in_req_i),
    .test_en_i  (test_en_i),
    .test_sel_i (test_sel_i),
    .elig_o     (elig)
  );

  cc_rr_pick #(.N_COLS(N_COLS), .COL_W(COL_W)) u_pick (
    .req_i   (elig),
    .last_i  (last_q),
    .valid_o (pick_vld),
    .idx_o   (pick_idx)
  );

  cc_ctrl u_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .any_i     (pick_vld),
    .out_ack_i (out_ack_i),
    .sel_req_i (in_req_i[col_q]),
    .state_o   (state),
    .grant_o   (grant)
  );

  // reset pointer to the top column so the first search begins at 0
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      col_q  <= '0;
      data_q <= '0;
      last_q <= COL_W'(N_COLS - 1);
      test_q <= 1'b0;
      sel_q  <= '0;
    end else if (grant) begin
      col_q  <= pick_idx;
      data_q <= in_data_i[pick_idx*DATA_W +: DATA_W];
      last_q <= pick_idx;
      test_q <= test_en_i;
      sel_q  <= test_sel_i;
    end
  end

  assign out_req_o  = (state == ST_OUT_REQ);
  assign out_data_o = {col_q, data_q};
  assign in_ack_o   = (state == ST_IN_ACK) ? (N_COLS'(1) << col_q) : '0;
endmodule

// File: rtl/col_collector_sva.sv
module col_collector_sva #(
  parameter int N_COLS = 32,
  parameter int DATA_W = 22,
  parameter int COL_W  = $clog2(N_COLS),
  parameter int OUT_W  = COL_W + DATA_W
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [N_COLS-1:0] in_req_i,
  input logic [N_COLS-1:0] in_ack_o,
  input logic              out_req_o,
  input logic              out_ack_i,
  input logic [OUT_W-1:0]  out_data_o,
  input logic              test_q,
  input logic [COL_W-1:0]  sel_q
);
  assert_one_ack_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(in_ack_o));

  assert_ack_after_out_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|in_ack_o) |-> !out_req_o);

  assert_ack_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(in_ack_o & in_req_i)) |=> $stable(in_ack_o));

  assert_ack_matches_tag_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|in_ack_o) |-> in_ack_o[out_data_o[OUT_W-1 -: COL_W]]);

  assert_out_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_req_o && !out_ack_i) |=> (out_req_o && $stable(out_data_o)));

  assert_test_isolation_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((|in_ack_o) && test_q) |-> in_ack_o[sel_q]);
endmodule

bind col_collector col_collector_sva #(
  .N_COLS(N_COLS), .DATA_W(DATA_W), .COL_W(COL_W), .OUT_W(OUT_W)
) u_sva (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .in_req_i   (in_req_i),
  .in_ack_o   (in_ack_o),
  .out_req_o  (out_req_o),
  .out_ack_i  (out_ack_i),
  .out_data_o (out_data_o),
  .test_q     (test_q),
  .sel_q      (sel_q)
);

// File: tb/tb_col_collector.sv
module tb_col_collector;
  localparam int CLK_PERIOD = 10;
  localparam int N  = 32;
  localparam int DW = 22;
  localparam int CW = 5;
  localparam int OW = 27;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [N-1:0]  req = '0;
  logic [N-1:0]  ack;
  logic [N*DW-1:0] in_data;
  logic          out_req;
  logic          out_ack = 1'b0;
  logic [OW-1:0] out_data;
  logic          test_en = 1'b0;
  logic [CW-1:0] test_sel = '0;
  logic [DW-1:0] dat [N];

  int checks = 0;
  int failures = 0;
  int last = N - 1;
  bit done = 0;
  bit hung = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  for (genvar g = 0; g < N; g++) begin : g_dat
    assign in_data[g*DW +: DW] = dat[g];
  end

  col_collector dut (
    .clk_i(clk), .rst_ni(rst_n), .in_req_i(req), .in_ack_o(ack),
    .in_data_i(in_data), .out_req_o(out_req), .out_ack_i(out_ack),
    .out_data_o(out_data), .test_en_i(test_en), .test_sel_i(test_sel)
  );

  task automatic chk(input bit ok, input string rq, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  // expected next column: round-robin from last+1, or the selected one in test mode
  function automatic int model_pick(input logic [N-1:0] pend, input bit ten, input int sel, input int lst);
    if (ten) return pend[sel] ? sel : -1;
    for (int k = 1; k <= N; k++) begin
      if (pend[(lst + k) % N]) return (lst + k) % N;
    end
    return -1;
  endfunction

  task automatic poll_req(input bit lvl);
    int n = 0;
    while (out_req !== lvl && n < 500) begin tick(); n++; end
    if (out_req !== lvl) begin hung = 1; chk(0, "R3 timeout out_req", out_req, lvl); end
  endtask

  task automatic poll_ack(input bit any);
    int n = 0;
    while ((|ack) !== any && n < 500) begin tick(); n++; end
    if ((|ack) !== any) begin hung = 1; chk(0, "R4 timeout in_ack", ack, any); end
  endtask

  task automatic serve(input int exp);
    poll_req(1);
    chk(out_data == {CW'(exp), dat[exp]}, "R2 R6 word/column", out_data, {CW'(exp), dat[exp]});
    chk(ack == '0, "R4 no ack before sink", ack, 0);
    out_ack = 1'b1;
    tick();
    poll_req(0);
    chk(ack == '0, "R4 no ack while sink ack high", ack, 0);
    out_ack = 1'b0;
    tick();
    poll_ack(1);
    chk(ack == (N'(1) << exp), "R4 R5 single ack to served column", ack, N'(1) << exp);
    tick(); tick();
    chk(ack == (N'(1) << exp), "R4 ack held while req high", ack, N'(1) << exp);
    req[exp] = 1'b0;
    tick();
    poll_ack(0);
    chk(!out_req, "R4 idle after ack release", out_req, 0);
    last = exp;
  endtask

  task automatic raise(input int c);
    dat[c] = DW'($urandom);
    req[c] = 1'b1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int e;
    void'($urandom(32'd2024));
    for (int i = 0; i < N; i++) dat[i] = '0;
    tick(); tick();
    chk(!out_req && ack == '0, "R1 outputs low in reset", {out_req, ack}, 0);
    rst_n = 1'b1;
    tick();
    chk(!out_req && ack == '0, "R1 outputs low after reset", {out_req, ack}, 0);

    // R3 latency, R6 start at column 0 after reset
    raise(5); raise(0);
    chk(!out_req, "R3 no req before edge", out_req, 0);
    tick();
    chk(out_req, "R3 req one edge after request", out_req, 1);
    tick(); tick();
    chk(out_req && out_data == {CW'(0), dat[0]}, "R3 R6 held, column 0 first", out_data, {CW'(0), dat[0]});
    serve(0);
    serve(5);

    // R6 wrap-around
    raise(31); raise(2); raise(30);
    serve(30); serve(31); serve(2);

    // R7 isolation
    test_en = 1'b1; test_sel = 5'd7;
    raise(2); raise(9);
    repeat (10) tick();
    chk(!out_req && ack == '0, "R7 unselected columns ignored", {out_req, ack}, 0);
    raise(7);
    serve(7);
    chk(req[2] && req[9] && ack == '0, "R7 others still pending", ack, 0);
    test_en = 1'b0;
    serve(9); serve(2);

    // R8 mode change during a transfer
    raise(3); raise(11);
    poll_req(1);
    test_en = 1'b1; test_sel = 5'd11;
    serve(3);
    serve(11);
    test_sel = 5'd20;
    raise(4);
    repeat (5) tick();
    chk(!out_req, "R8 new select applies at idle", out_req, 0);
    test_en = 1'b0;
    serve(4);

    // random phase
    for (int it = 0; it < 300 && !hung; it++) begin
      for (int c = 0; c < N; c++) if (!req[c] && ($urandom % 4 == 0)) raise(c);
      test_en  = ($urandom % 5 == 0);
      test_sel = CW'($urandom);
      e = model_pick(req, test_en, int'(test_sel), last);
      if (e < 0) begin
        repeat (6) tick();
        chk(!out_req && ack == '0, "R7 selected idle column, nothing served", {out_req, ack}, 0);
        raise(int'(test_sel));
        e = int'(test_sel);
      end
      serve(e);
    end
    test_en = 1'b0;
    while (req != '0 && !hung) serve(model_pick(req, 1'b0, 0, last));

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule